// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Period-Buffered Duty

This block drives a set of pulse-width outputs from one shared up/down counter. Each period starts at the modulo value. The counter steps down to zero and then steps back up. The period ends one count short of the modulo, where the counter turns around again. Each output is high while the count is below that channel's duty value, so the pulse sits in the middle of the period.

A host programs the modulo and the per-channel duty values through a simple write port. Every write goes into a holding register and raises a pending flag. The held value moves into the working register only at the edge that closes a period. A duty or modulo change therefore never splits a period. A zero duty value, or any duty value with the top bit set, keeps the output low for the whole period. This holds in whichever half of the period the write arrives.

An enable input parks the counter at the modulo and holds every output low while it is low. The first cycle after enable rises is a period start.

Top module: `pwm_center`

## Requirements
- R1: With modulo M (1 to 65535), one period lasts 2·M clocks. The count runs M, M−1, …, 1, 0, 1, …, M−1 and then returns to M. `periodStart` is high for exactly the one cycle in which the count equals M at the start of a period.
- R2: A channel whose working duty value V has bit 15 clear drives its output high in exactly those cycles where count < V (unsigned). This gives 2·V−1 high cycles per period for 1 ≤ V ≤ M, including V = M−1 and V = M, and 2·M high cycles (always high) for V > M.
- R3: A working duty value of 0x0000 keeps the output low for every cycle of the period, including the cycle where the count is zero.
- R4: A working duty value with bit 15 set (0x8000 to 0xFFFF) is treated as negative and keeps the output low for the whole period.
- R5: A duty write during the falling half of a period does not change the output in the rest of that period. The new value applies from the next period.
- R6: A duty write during the rising half of a period does not change the output in the rest of that period. The period completes with the old value, and the new value applies from the next period.
- R7: A write lands in a holding register and sets a pending flag. The working register is loaded only at the edge that ends a period (count M−1, rising). A write that arrives on that same edge is held until the following period boundary.
- R8: A modulo write is buffered in the same way. The current period keeps its length, and the next period is 2·M′ long and starts at the count M′.
- R9: While `enable` is low, from the next cycle onward all outputs and `periodStart` are low, the count is parked at the modulo, and pending values are loaded. The first cycle after `enable` returns high is a period start.
- R10: Write address 0 selects the modulo. Address k (1 to NUM_CH) selects the duty value of channel k−1. Writes to any other address change nothing.
- R11: After reset the modulo is DEF_MOD (100 by default), every duty value is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low parks the counter and silences outputs |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | ADDR_W | Register select: 0 = modulo, k = channel k−1 |
| wrData | input | CNT_W | Value written |
| pwmOut | output | NUM_CH | One pulse output per channel, active high |
| periodStart | output | 1 | High in the first cycle of each period |

## Verification
All outputs are decoded from registers. A change captured at a rising edge is therefore visible in the cycle after that edge, and the bench samples every output at the falling edge in between. A write driven in cycle p is stored at the end of p, but it reaches the output only in the first cycle of the next period. A write driven in the last cycle of a period reaches the output one period later still. The `enable` input takes effect one cycle after it is sampled. The bench keeps its own position-in-period model, advanced at the same edges. It checks every output against that model in every cycle, and it also counts high cycles and the period length over whole periods.

// File: rtl/pwm_center_pkg.sv
package pwm_center_pkg;

  // Strobes and state flags passed from the counter control to the datapath.
  typedef struct packed {
    logic xfer;     // load pending buffers into working registers at this edge
    logic running;  // counter is live (enable seen on a previous edge)
    logic dirUp;    // counter is in the rising half
  } ctl_strb_t;

  function automatic int addrBits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pwm_center_ctrl.sv
module pwm_center_ctrl
  import pwm_center_pkg::*;
#(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] DEF_MOD = CNT_W'(100)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] modAct,
  input  logic [CNT_W-1:0] modNext,
  output logic [CNT_W-1:0] count,
  output ctl_strb_t        strb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             running;
  logic             dirUp;
  logic             atTop;
  logic [CNT_W-1:0] countInc;
  logic [CNT_W-1:0] countDec;

  assign countInc = count + ONE;
  assign countDec = count - ONE;

  // Last cycle of a period: rising half, one below the modulo (R1, R7)
  assign atTop = running && dirUp && (countInc == modAct);

  always_comb begin
    strb.xfer    = !enable || !running || atTop;
    strb.running = running;
    strb.dirUp   = dirUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= DEF_MOD;
      running <= 1'b0;
      dirUp   <= 1'b0;
    end else if (!enable || !running) begin
      // Parked (R9): hold at the modulo that the next period will use
      count   <= modNext;
      dirUp   <= 1'b0;
      running <= enable;
    end else if (!dirUp) begin
      count <= countDec;
      if (count == ONE) dirUp <= 1'b1;
    end else if (atTop) begin
      count <= modNext;
      dirUp <= 1'b0;
    end else begin
      count <= countInc;
    end
  end

endmodule

// File: rtl/pwm_center_cmp.sv
module pwm_center_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             running,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  output logic             active
);

  logic dark;

  // Zero (R3) and sign-set (R4) levels force a silent period
  assign dark   = (level == '0) || level[CNT_W-1];
  assign active = running && !dark && (count < level);

endmodule

// File: rtl/pwm_center_dp.sv
module pwm_center_dp
  import pwm_center_pkg::*;
#(
  parameter int               NUM_CH  = 4,
  parameter int               CNT_W   = 16,
  parameter int               ADDR_W  = 3,
  parameter logic [CNT_W-1:0] DEF_MOD = CNT_W'(100)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [CNT_W-1:0]             wrData,
  input  logic [CNT_W-1:0]             count,
  input  ctl_strb_t                    strb,
  output logic [CNT_W-1:0]             modAct,
  output logic [CNT_W-1:0]             modNext,
  output logic [NUM_CH-1:0][CNT_W-1:0] chActive,
  output logic [NUM_CH-1:0]            pwmOut,
  output logic                         periodStart
);

  logic [CNT_W-1:0] modBuf;
  logic             modPend;
  logic             wrMod;

  assign wrMod = wrEn && (wrAddr == '0);  // R10 address 0

  // Modulo holding / working pair (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modBuf  <= DEF_MOD;
      modAct  <= DEF_MOD;
      modPend <= 1'b0;
    end else begin
      if (wrMod) modBuf <= wrData;
      if (strb.xfer && modPend) modAct <= modBuf;
      modPend <= wrMod || (modPend && !strb.xfer);
    end
  end

  assign modNext = modPend ? modBuf : modAct;

  // Per-channel holding / working pair and comparator (R5, R6, R7)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] bufVal;
    logic [CNT_W-1:0] actVal;
    logic             pend;
    logic             hit;

    assign hit = wrEn && (wrAddr == ADDR_W'(g + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufVal <= '0;
        actVal <= '0;
        pend   <= 1'b0;
      end else begin
        if (hit) bufVal <= wrData;
        if (strb.xfer && pend) actVal <= bufVal;
        pend <= hit || (pend && !strb.xfer);
      end
    end

    assign chActive[g] = actVal;

    pwm_center_cmp #(.CNT_W(CNT_W)) u_cmp (
      .running (strb.running),
      .count   (count),
      .level   (actVal),
      .active  (pwmOut[g])
    );
  end

  // R1: first cycle of a period sits at the modulo in the falling half
  assign periodStart = strb.running && !strb.dirUp && (count == modAct);

endmodule

// File: rtl/pwm_center.sv
module pwm_center
  import pwm_center_pkg::*;
#(
  parameter int               NUM_CH  = 4,
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] DEF_MOD = CNT_W'(100),
  localparam int              ADDR_W  = addrBits(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              periodStart
);

  logic [CNT_W-1:0]             count;
  logic [CNT_W-1:0]             modAct;
  logic [CNT_W-1:0]             modNext;
  logic [NUM_CH-1:0][CNT_W-1:0] chActive;
  ctl_strb_t                    strb;

  pwm_center_ctrl #(.CNT_W(CNT_W), .DEF_MOD(DEF_MOD)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .modAct  (modAct),
    .modNext (modNext),
    .count   (count),
    .strb    (strb)
  );

  pwm_center_dp #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DEF_MOD(DEF_MOD)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .count       (count),
    .strb        (strb),
    .modAct      (modAct),
    .modNext     (modNext),
    .chActive    (chActive),
    .pwmOut      (pwmOut),
    .periodStart (periodStart)
  );

endmodule

// File: rtl/pwm_center_chk.sv
module pwm_center_chk
  import pwm_center_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         enable,
  input logic [NUM_CH-1:0]            pwmOut,
  input logic                         periodStart,
  input logic [CNT_W-1:0]             count,
  input logic [CNT_W-1:0]             modAct,
  input logic [NUM_CH-1:0][CNT_W-1:0] chActive,
  input ctl_strb_t                    strb
);

  p_single_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  p_count_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.running |-> (count <= modAct));

  p_mod_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xfer |=> $stable(modAct));

  p_off_dark_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == '0 && !periodStart));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !strb.xfer |=> $stable(chActive[g]));

    p_zero_dark_r3: assert property (@(posedge clk) disable iff (!rstN)
      (chActive[g] == '0) |-> !pwmOut[g]);

    p_neg_dark_r4: assert property (@(posedge clk) disable iff (!rstN)
      chActive[g][CNT_W-1] |-> !pwmOut[g]);

    p_full_on_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.running && !chActive[g][CNT_W-1] && (chActive[g] > modAct)) |-> pwmOut[g]);
  end

endmodule

bind pwm_center pwm_center_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .pwmOut      (pwmOut),
  .periodStart (periodStart),
  .count       (count),
  .modAct      (modAct),
  .chActive    (chActive),
  .strb        (strb)
);

// File: tb/sim_pwm_center.sv
`timescale 1ns/1ps
module sim_pwm_center;

  localparam int          NUM_CH  = 4;
  localparam int          ADDR_W  = 3;
  localparam logic [15:0] DEF_MOD = 16'd100;
  localparam int          NVEC    = 12;

  // {modulo, duty, expected high cycles per period}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd10, 16'h0000, 16'd0},
    {16'd10, 16'h8000, 16'd0},
    {16'd10, 16'hFFFF, 16'd0},
    {16'd10, 16'h0001, 16'd1},
    {16'd10, 16'h0005, 16'd9},
    {16'd10, 16'h0009, 16'd17},
    {16'd10, 16'h000A, 16'd19},
    {16'd10, 16'h000B, 16'd20},
    {16'd10, 16'h7FFF, 16'd20},
    {16'd3,  16'h0002, 16'd3},
    {16'd1,  16'h0001, 16'd1},
    {16'd1,  16'h0002, 16'd2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0]       wrData = '0;
  logic [NUM_CH-1:0] pwmOut;
  logic              periodStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_center #(.NUM_CH(NUM_CH), .CNT_W(16), .DEF_MOD(DEF_MOD)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .periodStart(periodStart)
  );

  // Reference: position inside the period, holding and working values
  logic [15:0] mBuf [0:NUM_CH];
  logic [15:0] mAct [0:NUM_CH];
  bit          mPend [0:NUM_CH];
  int          mPos;
  bit          mRun;
  bit          mEdge;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k <= NUM_CH; k++) begin
        mBuf[k]  <= (k == 0) ? DEF_MOD : 16'd0;
        mAct[k]  <= (k == 0) ? DEF_MOD : 16'd0;
        mPend[k] <= 1'b0;
      end
      mPos <= 0;
      mRun <= 1'b0;
    end else begin
      mEdge = !enable || !mRun || (mPos == 2 * int'(mAct[0]) - 1);
      for (int k = 0; k <= NUM_CH; k++) begin
        if (mEdge && mPend[k]) mAct[k] <= mBuf[k];
        if (wrEn && int'(wrAddr) == k) begin
          mBuf[k]  <= wrData;
          mPend[k] <= 1'b1;
        end else if (mEdge) begin
          mPend[k] <= 1'b0;
        end
      end
      mPos <= mEdge ? 0 : mPos + 1;
      mRun <= enable;
    end
  end

  function automatic logic [NUM_CH-1:0] expPwm();
    int c;
    logic [NUM_CH-1:0] r;
    c = (mPos <= int'(mAct[0])) ? int'(mAct[0]) - mPos : mPos - int'(mAct[0]);
    for (int k = 0; k < NUM_CH; k++)
      r[k] = mRun && !mAct[k+1][15] && (c < int'(mAct[k+1]));
    return r;
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference (R1, R2)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chkEq("R2 pwm vs model", int'(pwmOut), int'(expPwm()));
      chkEq("R1 start vs model", int'(periodStart), int'(mRun && mPos == 0));
    end
  end

  task automatic wr(input int addr, input logic [15:0] data);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Runs one period from its start cycle; writes nw values at base+k in cycle p0+k
  task automatic runPeriod(input int base, input int p0, input int nw,
                           input logic [15:0] v0, input logic [15:0] v1, input logic [15:0] v2,
                           output int h0, output int h1, output int h2, output int len);
    h0 = 0; h1 = 0; h2 = 0; len = 0;
    do begin
      wrEn = 1'b0;
      if (len >= p0 && len < p0 + nw) begin
        wrEn   = 1'b1;
        wrAddr = ADDR_W'(base + len - p0);
        wrData = (len == p0) ? v0 : (len == p0 + 1) ? v1 : v2;
      end
      h0 += int'(pwmOut[0]); h1 += int'(pwmOut[1]); h2 += int'(pwmOut[2]);
      len++;
      @(negedge clk);
    end while (!periodStart);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h0, h1, h2, len;
    logic [15:0] vm, vv, ve;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chkEq("R11 outputs low after reset", int'(pwmOut), 0);
    chkEq("R11 no start after reset", int'(periodStart), 0);
    enable = 1'b1;
    @(negedge clk);
    chkEq("R9 start after enable", int'(periodStart), 1);
    runPeriod(0, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R11 default period", len, 2 * int'(DEF_MOD));
    chkEq("R11 default duty ch0", h0, 0);
    chkEq("R11 default duty ch2", h2, 0);

    // Vector table: duty per period across values and moduli (R1, R2, R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      vm = VEC[i][47:32]; vv = VEC[i][31:16]; ve = VEC[i][15:0];
      enable = 1'b0;
      wr(0, vm);
      wr(1, vv);
      @(negedge clk); @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      chkEq("R9 start after enable", int'(periodStart), 1);
      runPeriod(0, 0, 0, 0, 0, 0, h0, h1, h2, len);
      chkEq((vv == 16'd0) ? "R3 zero duty" : vv[15] ? "R4 negative duty" : "R2 duty count",
            h0, int'(ve));
      chkEq("R1 period length", len, 2 * int'(vm));
    end

    // Directed setup: modulo 10, channels zero
    enable = 1'b0;
    wr(0, 16'd10); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);

    // R5: writes in the falling half wait for the next period
    runPeriod(1, 3, 3, 16'd5, 16'd9, 16'd10, h0, h1, h2, len);
    chkEq("R5 ch0 unchanged this period", h0, 0);
    chkEq("R5 ch1 unchanged this period", h1, 0);
    chkEq("R5 ch2 unchanged this period", h2, 0);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R5 ch0 new duty", h0, 9);
    chkEq("R2 ch1 modulo-1", h1, 17);
    chkEq("R2 ch2 modulo", h2, 19);

    // R6: zero and negative writes in the rising half finish with old values
    runPeriod(1, 13, 3, 16'h0000, 16'h8000, 16'hFFFF, h0, h1, h2, len);
    chkEq("R6 ch0 old duty kept", h0, 9);
    chkEq("R6 ch1 old duty kept", h1, 17);
    chkEq("R6 ch2 old duty kept", h2, 19);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R3 ch0 zero after boundary", h0, 0);
    chkEq("R4 ch1 negative after boundary", h1, 0);
    chkEq("R4 ch2 negative after boundary", h2, 0);

    // R5 from zero to large values in the falling half
    runPeriod(1, 2, 3, 16'h7FFF, 16'h8001, 16'd1, h0, h1, h2, len);
    chkEq("R5 ch0 still dark", h0, 0);
    chkEq("R5 ch2 still dark", h2, 0);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R2 ch0 above modulo", h0, 20);
    chkEq("R4 ch1 negative", h1, 0);
    chkEq("R2 ch2 minimum", h2, 1);

    // R6: modulo-1 and modulo written in the rising half
    runPeriod(1, 12, 3, 16'd9, 16'd10, 16'd0, h0, h1, h2, len);
    chkEq("R6 ch0 old duty kept", h0, 20);
    chkEq("R6 ch2 old duty kept", h2, 1);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R6 ch0 modulo-1 next", h0, 17);
    chkEq("R6 ch1 modulo next", h1, 19);

    // R7: write on the boundary edge is deferred one more period
    runPeriod(1, 19, 1, 16'd3, 0, 0, h0, h1, h2, len);
    chkEq("R7 ch0 current", h0, 17);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R7 ch0 still old", h0, 17);
    runPeriod(1, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R7 ch0 applied", h0, 5);

    // R8: modulo change waits for the boundary
    runPeriod(0, 5, 1, 16'd6, 0, 0, h0, h1, h2, len);
    chkEq("R8 current period length", len, 20);
    runPeriod(0, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R8 new period length", len, 12);
    chkEq("R8 ch0 duty", h0, 5);
    chkEq("R8 ch1 above new modulo", h1, 12);

    // R10: unmapped addresses have no effect
    runPeriod(5, 2, 3, 16'd1, 16'd1, 16'd1, h0, h1, h2, len);
    runPeriod(0, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R10 period unchanged", len, 12);
    chkEq("R10 ch0 unchanged", h0, 5);
    chkEq("R10 ch1 unchanged", h1, 12);
    chkEq("R10 ch2 unchanged", h2, 0);

    // R9: enable low mid-period
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chkEq("R9 outputs low when disabled", int'(pwmOut), 0);
    chkEq("R9 no start when disabled", int'(periodStart), 0);
    wr(1, 16'd2);
    for (int i = 0; i < 3; i++) begin
      chkEq("R9 outputs stay low", int'(pwmOut), 0);
      @(negedge clk);
    end
    enable = 1'b1;
    @(negedge clk);
    chkEq("R9 start on re-enable", int'(periodStart), 1);
    runPeriod(0, 0, 0, 0, 0, 0, h0, h1, h2, len);
    chkEq("R9 pending loaded while parked", h0, 3);
    chkEq("R9 period length", len, 12);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule